// File: doc/BRIEF.md
# Partitioned SIMD Integer Execution Unit

This block is a 128-bit integer execution unit that works on packed data. Each operation carries three 128-bit operands, a three-bit operation code, a two-bit element-size code and a packed/scalar flag. The register is split into equal lanes of 8, 16, 32 or 64 bits. Lane-wise add and lane-wise multiply-add work on every lane at once. The carry chain is cut at each lane edge, and those edges are chosen per operation.

Three further operations move data between the two 64-bit halves of the register. One copies the low 64 bits of the second operand into both halves. One replaces the upper half of the first operand. One replaces the lower half of the first operand.

A request marked valid is captured on the next rising clock edge. The result leaves the block from a register, together with a valid flag, one cycle later. The result register keeps its value when no request is presented.

Top module: `simd_lane_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid` goes to 0 and `result` goes to all zeros.
- R2: `out_valid` in a cycle equals `in_valid` sampled at the previous rising edge. `result` is loaded only at edges where `in_valid` is 1 and otherwise keeps its value.
- R3: `esize` selects the lane width W: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i occupies bits [(i+1)·W−1 : i·W]. Opcode 0 adds `src_a` and `src_b` lane by lane, modulo 2^W, and no carry passes from one lane into the next.
- R4: Opcode 1 computes `src_a + (src_b × src_c)` in each lane. The product is truncated to W bits and the sum wraps modulo 2^W.
- R5: With `scalar` at 0, opcodes 0 and 1 produce every lane of the result.
- R6: With `scalar` at 1, opcodes 0 and 1 compute only lane 0 of the selected width. All result bits above lane 0 are copied from `src_a`.
- R7: Opcode 2 writes `src_b[63:0]` into both `result[63:0]` and `result[127:64]`.
- R8: Opcode 3 gives `{src_b[127:64], src_a[63:0]}`.
- R9: Opcode 4 gives `{src_a[127:64], src_b[63:0]}`.
- R10: For opcodes 2 to 4 the `scalar` and `esize` inputs have no effect. Opcodes 5 to 7 return `src_a` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| op | input | 3 | Operation code (0 add, 1 multiply-add, 2 broadcast-low, 3 move-high, 4 move-low) |
| esize | input | 2 | Lane width code (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits) |
| scalar | input | 1 | 1 = compute lane 0 only |
| src_a | input | 128 | First operand; also the accumulator and the pass-through source |
| src_b | input | 128 | Second operand |
| src_c | input | 128 | Third operand (multiplier for multiply-add) |
| out_valid | output | 1 | Result register holds a new result |
| result | output | 128 | Registered result |

## Verification
For every lane width, the bench drives all-ones lanes plus one, and lanes with only the top bit set plus the same value. This puts a carry out of every lane edge. A design that joins lanes, or cuts them at the wrong width, then leaves a stray 1 in the next lane's least significant bit.

Scalar requests are sent with upper bits of `src_a` and `src_b` that differ from each other. A design that computes all lanes, or zeroes the upper part, shows the wrong upper bits.

Further vectors target specific faults:
- **Half moves:** the two operands differ in each half, so a swapped or misplaced half shows up.
- **Multiply-add:** large operands expose a product that is not truncated, or one that is taken from the wrong lane slice.
- **Hold:** idle cycles with changing inputs expose a result register that loads without `in_valid`.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'd0,
    OP_MADD  = 3'd1,
    OP_BCAST = 3'd2,
    OP_MOVH  = 3'd3,
    OP_MOVL  = 3'd4
  } simd_op_e;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } elem_size_e;

endpackage

// File: rtl/lane_adder.sv
// Segmented adder: byte slices whose carry-in is forced to zero at lane starts.
module lane_adder #(
  parameter int DATA_W  = 128,
  parameter int SLICE_W = 8
) (
  input  logic [1:0]        esize,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] sum
);
  localparam int NSLICE = DATA_W / SLICE_W;

  logic [2:0]        lane_mask;
  logic [NSLICE-1:0] cy;

  always_comb begin
    case (esize)
      2'd0:    lane_mask = 3'b000;
      2'd1:    lane_mask = 3'b001;
      2'd2:    lane_mask = 3'b011;
      default: lane_mask = 3'b111;
    endcase
  end

  assign cy[0] = 1'b0;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    localparam logic [2:0] KLOW = 3'(k);
    logic cin;
    assign cin = ((KLOW & lane_mask) == 3'b000) ? 1'b0 : cy[k];
    if (k < NSLICE - 1) begin : g_mid
      logic [SLICE_W:0] part;
      assign part = {1'b0, opa[k*SLICE_W +: SLICE_W]}
                  + {1'b0, opb[k*SLICE_W +: SLICE_W]}
                  + {{SLICE_W{1'b0}}, cin};
      assign sum[k*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
      assign cy[k+1] = part[SLICE_W];
    end else begin : g_top
      assign sum[k*SLICE_W +: SLICE_W] = opa[k*SLICE_W +: SLICE_W]
                                       + opb[k*SLICE_W +: SLICE_W]
                                       + {{(SLICE_W-1){1'b0}}, cin};
    end
  end

endmodule

// File: rtl/lane_multiplier.sv
// One bank of truncated multipliers per lane width; esize picks the bank.
module lane_multiplier #(
  parameter int DATA_W = 128
) (
  input  logic [1:0]        esize,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] opc,
  output logic [DATA_W-1:0] prod
);
  localparam int NSIZE = 4;

  logic [NSIZE-1:0][DATA_W-1:0] by_size;

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    localparam int W = 8 << s;
    localparam int N = DATA_W / W;
    for (genvar i = 0; i < N; i++) begin : g_lane
      assign by_size[s][i*W +: W] = opb[i*W +: W] * opc[i*W +: W];
    end
  end

  assign prod = by_size[esize];

endmodule

// File: rtl/half_shuffler.sv
module half_shuffler #(
  parameter int DATA_W = 128
) (
  input  simd_pkg::simd_op_e op,
  input  logic [DATA_W-1:0]  opa,
  input  logic [DATA_W-1:0]  opb,
  output logic [DATA_W-1:0]  shuf
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    case (op)
      simd_pkg::OP_BCAST: shuf = {opb[HALF_W-1:0], opb[HALF_W-1:0]};
      simd_pkg::OP_MOVH:  shuf = {opb[DATA_W-1:HALF_W], opa[HALF_W-1:0]};
      simd_pkg::OP_MOVL:  shuf = {opa[DATA_W-1:HALF_W], opb[HALF_W-1:0]};
      default:            shuf = opa;
    endcase
  end

endmodule

// File: rtl/simd_lane_unit.sv
module simd_lane_unit #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op,
  input  logic [1:0]        esize,
  input  logic              scalar,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] src_c,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  import simd_pkg::*;

  localparam int HALF_W = DATA_W / 2;

  simd_op_e          op_e;
  logic [DATA_W-1:0] prod, addend, sum, shuf, low_mask, arith, next_res;

  assign op_e   = simd_op_e'(op);
  assign addend = (op_e == OP_MADD) ? prod : src_b;

  lane_multiplier #(.DATA_W(DATA_W)) u_mul (
    .esize(esize), .opb(src_b), .opc(src_c), .prod(prod)
  );

  lane_adder #(.DATA_W(DATA_W), .SLICE_W(8)) u_add (
    .esize(esize), .opa(src_a), .opb(addend), .sum(sum)
  );

  half_shuffler #(.DATA_W(DATA_W)) u_shuf (
    .op(op_e), .opa(src_a), .opb(src_b), .shuf(shuf)
  );

  // Lowest-element mask for scalar mode
  always_comb begin
    case (esize)
      2'd0:    low_mask = DATA_W'({8{1'b1}});
      2'd1:    low_mask = DATA_W'({16{1'b1}});
      2'd2:    low_mask = DATA_W'({32{1'b1}});
      default: low_mask = DATA_W'({64{1'b1}});
    endcase
  end

  assign arith = scalar ? ((sum & low_mask) | (src_a & ~low_mask)) : sum;

  always_comb begin
    case (op_e)
      OP_ADD, OP_MADD:           next_res = arith;
      OP_BCAST, OP_MOVH, OP_MOVL: next_res = shuf;
      default:                   next_res = src_a;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end

  // Output timing and hold
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  // A 64-bit lane add must match a plain 64-bit sum of the low halves
  assert_wide_lane_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd0 && esize == 2'd3 && !scalar) |=>
      result[HALF_W-1:0] == $past(HALF_W'(src_a[HALF_W-1:0] + src_b[HALF_W-1:0])));

  // Scalar arithmetic keeps the upper half of the first operand
  assert_scalar_upper_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar && (op == 3'd0 || op == 3'd1)) |=>
      result[DATA_W-1:HALF_W] == $past(src_a[DATA_W-1:HALF_W]));

  assert_bcast_halves_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd2) |=> result[DATA_W-1:HALF_W] == result[HALF_W-1:0]);

  assert_movh_low_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd3) |=> result[HALF_W-1:0] == $past(src_a[HALF_W-1:0]));

  assert_movl_high_R9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 3'd4) |=> result[DATA_W-1:HALF_W] == $past(src_a[DATA_W-1:HALF_W]));

  assert_passthru_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > 3'd4) |=> result == $past(src_a));

endmodule

// File: tb/simd_lane_unit_bench.sv
module simd_lane_unit_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [2:0]   op = '0;
  logic [1:0]   esize = '0;
  logic         scalar = 1'b0;
  logic [127:0] src_a = '0, src_b = '0, src_c = '0;
  logic         out_valid;
  logic [127:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  simd_lane_unit u_simd_lane_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .esize(esize),
    .scalar(scalar), .src_a(src_a), .src_b(src_b), .src_c(src_c),
    .out_valid(out_valid), .result(result)
  );

  // Behavioural reference, lane by lane
  function automatic logic [127:0] ref_calc(input logic [2:0] o, input logic [1:0] sz,
      input logic sc, input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    logic [127:0] m, r, ea, eb, ec, e;
    int w, n;
    w = 8 << sz;
    n = sc ? 1 : 128 / w;
    m = (128'd1 << w) - 128'd1;
    case (o)
      3'd0, 3'd1: begin
        r = sc ? (a & ~m) : '0;
        for (int i = 0; i < n; i++) begin
          ea = (a >> (i*w)) & m;
          eb = (b >> (i*w)) & m;
          ec = (c >> (i*w)) & m;
          e  = (o == 3'd0) ? ((ea + eb) & m) : ((ea + eb * ec) & m);
          r  = r | (e << (i*w));
        end
      end
      3'd2: r = {b[63:0], b[63:0]};
      3'd3: r = {b[127:64], a[63:0]};
      3'd4: r = {a[127:64], b[63:0]};
      default: r = a;
    endcase
    return r;
  endfunction

  function automatic logic [127:0] lane_fill(input logic [1:0] sz, input logic [63:0] v);
    logic [127:0] r;
    int w;
    w = 8 << sz;
    r = '0;
    for (int i = 0; i < 128 / w; i++)
      r = r | ((128'(v) & ((128'd1 << w) - 128'd1)) << (i*w));
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s result act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s valid act=%b exp=%b", tag, act, exp);
    end
  endtask

  // Drive one request, check it one cycle later
  task automatic run_op(input string tag, input logic [2:0] o, input logic [1:0] sz,
      input logic sc, input logic [127:0] a, input logic [127:0] b, input logic [127:0] c);
    logic [127:0] exp;
    @(negedge clk);
    op = o; esize = sz; scalar = sc; src_a = a; src_b = b; src_c = c; in_valid = 1'b1;
    exp = ref_calc(o, sz, sc, a, b, c);
    @(negedge clk);
    in_valid = 1'b0;
    check_bit(tag, out_valid, 1'b1);
    check(tag, result, exp);
  endtask

  string tg;

  initial begin
    logic [127:0] last;
    logic [127:0] ra, rb, rc;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_bit("R1", out_valid, 1'b0);
    check("R1", result, '0);
    rst = 1'b0;

    // R3 carry at every lane edge, each size; R5 all lanes packed
    for (int s = 0; s < 4; s++) begin
      run_op("R3", 3'd0, 2'(s), 1'b0, '1, lane_fill(2'(s), 64'd1), '0);
      run_op("R3", 3'd0, 2'(s), 1'b0, lane_fill(2'(s), 64'd1 << ((8<<s)-1)),
             lane_fill(2'(s), 64'd1 << ((8<<s)-1)), '0);
      run_op("R5", 3'd0, 2'(s), 1'b0, {4{32'h89AB_CDEF}}, {4{32'h7654_3211}}, '0);
      // R4 multiply-add with overflowing products
      run_op("R4", 3'd1, 2'(s), 1'b0, '1, '1, lane_fill(2'(s), 64'd3));
      run_op("R4", 3'd1, 2'(s), 1'b0, {4{32'h0102_0304}}, {4{32'hF0E1_D2C3}}, {4{32'h5A5A_A5A5}});
      // R6 scalar
      run_op("R6", 3'd0, 2'(s), 1'b1, '1, '1, '1);
      run_op("R6", 3'd1, 2'(s), 1'b1, {4{32'h1234_5678}}, {4{32'hFFEE_DDCC}}, {4{32'h0F0F_1111}});
    end

    // R7..R9 half moves, R10 scalar/esize ignored and pass-through
    ra = {64'hAAAA_1111_2222_3333, 64'h4444_5555_6666_7777};
    rb = {64'h8888_9999_CCCC_DDDD, 64'hEEEE_FFFF_0123_4567};
    run_op("R7", 3'd2, 2'd0, 1'b0, ra, rb, '0);
    run_op("R8", 3'd3, 2'd1, 1'b0, ra, rb, '0);
    run_op("R9", 3'd4, 2'd2, 1'b0, ra, rb, '0);
    run_op("R10", 3'd2, 2'd0, 1'b1, ra, rb, '0);
    run_op("R10", 3'd3, 2'd0, 1'b1, ra, rb, '0);
    run_op("R10", 3'd4, 2'd3, 1'b1, ra, rb, '0);
    run_op("R10", 3'd5, 2'd0, 1'b0, ra, rb, rb);
    run_op("R10", 3'd7, 2'd1, 1'b1, ra, rb, rb);

    // R2 hold while idle with changing inputs
    run_op("R2", 3'd0, 2'd2, 1'b0, ra, rb, '0);
    last = ref_calc(3'd0, 2'd2, 1'b0, ra, rb, '0);
    @(negedge clk);
    src_a = '1; src_b = '1; op = 3'd2;
    @(negedge clk);
    check_bit("R2", out_valid, 1'b0);
    check("R2", result, last);

    // Random mix
    for (int k = 0; k < 300; k++) begin
      logic [2:0] o;
      logic [1:0] sz;
      logic sc;
      o  = 3'($urandom_range(0, 7));
      sz = 2'($urandom);
      sc = 1'($urandom);
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      rc = {$urandom, $urandom, $urandom, $urandom};
      case (o)
        3'd0: tg = sc ? "R6" : "R3";
        3'd1: tg = sc ? "R6" : "R4";
        3'd2: tg = "R7";
        3'd3: tg = "R8";
        3'd4: tg = "R9";
        default: tg = "R10";
      endcase
      run_op(tg, o, sz, sc, ra, rb, rc);
    end

    // R1 reset mid-run
    run_op("R3", 3'd0, 2'd0, 1'b0, ra, rb, '0);
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    check_bit("R1", out_valid, 1'b0);
    check("R1", result, '0);
    rst = 1'b0; in_valid = 1'b0;

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule